// File: doc/BRIEF.md
# Self-Motivated Slave-Port Arbiter

This block sits in front of one slave port of a multi-layer interconnect and decides which of up to eight master layers owns that port. Each master carries its own priority level and a desired transfer length in the upper bits of its address. Every selection starts with a check of the priority levels of the current requesters. If they are all equal, the arbiter uses round-robin selection. If they differ, the master with the highest level wins. A per-port length counter then keeps the chosen master in place for the number of beats it asked for.

Combining the two selection policies with the length counter gives several arbitration behaviours without any reconfiguration. One transfer per grant is a length of one. A whole burst per grant is a length that matches the burst and lets the transaction end release the port. A chosen number of beats is any other length. A master's lock overrides the counter. When nobody owns the port, a registered flag forces the slave-side transfer type to IDLE.

The interconnect passes each master's address bits 28 down to 22 to this block. It also passes the decoder select for this slave, the transfer type, the lock signal and the slave's ready signal.

Top module: `sm_port_arbiter`

## Requirements
- R1: After reset, `grant_idx_o` is 0, `no_port_o` is 1 and `trans_o` is IDLE.
- R2: For master m, bits [6:4] of `addr_ctl_i[m*7 +: 7]` (address bits 28..26) are its priority level, where a larger value wins. Bits [3:0] (address bits 25..22) are its length code. Code L gives L beats, and code 0 gives 16 beats.
- R3: When the port has no owner and no select is high, the next ready edge leaves `no_port_o` at 1. On that edge, any requester becomes the owner.
- R4: When all requesting priority levels are equal, the winner is the first requester after the most recently granted master, in circular index order. After reset, that search starts at master 0.
- R5: When requesting priority levels differ, the winner is the requester with the highest level. Among equal highest levels, the lowest index wins.
- R6: While the owner holds its lock high, it stays selected on every ready edge, whatever the other requests and the counter.
- R7: An owner granted with length N keeps the port through N ready edges after the grant edge. On the N-th of those edges, a different requester takes over.
- R8: When the length has run out and no other master requests, the owner is kept with `no_port_o` at 0 if its select is high. If its select is low, `no_port_o` goes to 1.
- R9: Before the length runs out, the owner's transaction ends when its select drops, when it presents IDLE, or when it presents NONSEQ after its first granted beat. The arbiter then picks again among all requesters, or sets `no_port_o` if there are none.
- R10: On a clock edge where `ready_i` is low, no output and no arbitration state changes.
- R11: A decision appears on `grant_idx_o` and `no_port_o` one clock after the edge that makes it, not before.
- R12: `trans_o` is IDLE (2'b00) while `no_port_o` is 1. Otherwise it is the transfer type of the selected master. The encoding is IDLE=0, BUSY=1, NONSEQ=2, SEQ=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | N_MST | Decoder select for this slave, one bit per master |
| addr_ctl_i | input | N_MST*7 | Address bits 28..22 of each master: {priority, length code} |
| trans_i | input | N_MST*2 | Transfer type of each master |
| lock_i | input | N_MST | Lock request of each master |
| ready_i | input | 1 | Slave ready; the current beat completes |
| grant_idx_o | output | IDX_W | Registered number of the selected master |
| no_port_o | output | 1 | Registered flag: no master owns the port |
| trans_o | output | 2 | Slave-side transfer type, forced to IDLE when no owner |

## Verification
The length code 0 case is checked by holding a master for exactly sixteen edges. A design that decoded the code as zero beats would switch at once, and one that counted N+1 beats would hold one edge too long. A NONSEQ on the grant beat must not end the transaction, while a later NONSEQ, an IDLE or a dropped select must end it. An off-by-one in the first-beat tracking would either give up the port immediately or never give it up early. On priority ties, round-robin must resume after the last granted master, and unequal levels must favour the lowest index. A mistaken pointer update or tie-break would grant the wrong master. The lock must outlast an expired counter, and the no-owner flag must hold on cycles where ready is low.

// File: rtl/sm_arb_pkg.sv
package sm_arb_pkg;
  localparam int PRIO_W = 3;
  localparam int LEN_W  = 4;
  localparam int CTL_W  = PRIO_W + LEN_W;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'd0,
    TR_BUSY   = 2'd1,
    TR_NONSEQ = 2'd2,
    TR_SEQ    = 2'd3
  } htrans_e;

  typedef enum logic [2:0] {
    ACT_PICK_ALL,
    ACT_PICK_OTH,
    ACT_RELEASE,
    ACT_KEEP_DEC,
    ACT_KEEP
  } act_e;
endpackage

// File: rtl/sm_field_extract.sv
module sm_field_extract
  import sm_arb_pkg::*;
#(
  parameter int N_MST = 8
) (
  input  logic [N_MST*CTL_W-1:0]  addr_ctl_i,
  output logic [N_MST*PRIO_W-1:0] prio_o,
  output logic [N_MST*LEN_W-1:0]  load_o
);
  for (genvar m = 0; m < N_MST; m++) begin : g_mst
    logic [LEN_W-1:0] code;
    assign code = addr_ctl_i[m*CTL_W +: LEN_W];
    assign prio_o[m*PRIO_W +: PRIO_W] = addr_ctl_i[m*CTL_W+LEN_W +: PRIO_W];
    // counter holds beats-1; code 0 wraps to 15, i.e. 16 beats
    assign load_o[m*LEN_W +: LEN_W] = code - LEN_W'(1);
  end
endmodule

// File: rtl/sm_master_pick.sv
module sm_master_pick
  import sm_arb_pkg::*;
#(
  parameter int N_MST = 8,
  localparam int IDX_W = $clog2(N_MST)
) (
  input  logic [N_MST-1:0]        req_i,
  input  logic [N_MST*PRIO_W-1:0] prio_i,
  input  logic [IDX_W-1:0]        last_i,
  output logic                    any_o,
  output logic [IDX_W-1:0]        win_o
);
  logic [PRIO_W-1:0] pmax, pmin, pbest, pcur;
  logic [IDX_W-1:0]  p_win, r_win;
  logic              p_found, r_found;

  always_comb begin
    any_o   = 1'b0;
    pmax    = '0;
    pmin    = '1;
    pbest   = '0;
    pcur    = '0;
    p_win   = '0;
    p_found = 1'b0;
    for (int i = 0; i < N_MST; i++) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        pcur  = prio_i[i*PRIO_W +: PRIO_W];
        if (pcur > pmax) pmax = pcur;
        if (pcur < pmin) pmin = pcur;
        if (!p_found || pcur > pbest) begin
          pbest   = pcur;
          p_win   = IDX_W'(i);
          p_found = 1'b1;
        end
      end
    end
  end

  always_comb begin
    r_win   = '0;
    r_found = 1'b0;
    for (int k = 1; k <= N_MST; k++) begin
      int j;
      j = int'(last_i) + k;
      if (j >= N_MST) j = j - N_MST;
      if (!r_found && req_i[j]) begin
        r_win   = IDX_W'(j);
        r_found = 1'b1;
      end
    end
  end

  assign win_o = (pmax == pmin) ? r_win : p_win;
endmodule

// File: rtl/sm_arb_ctrl.sv
module sm_arb_ctrl
  import sm_arb_pkg::*;
#(
  parameter int N_MST = 8,
  localparam int IDX_W = $clog2(N_MST)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_MST-1:0]        sel_i,
  input  logic [N_MST*2-1:0]      trans_i,
  input  logic [N_MST-1:0]        lock_i,
  input  logic                    ready_i,
  input  logic [N_MST*PRIO_W-1:0] prio_i,
  input  logic [N_MST*LEN_W-1:0]  load_i,
  output logic [IDX_W-1:0]        cur_o,
  output logic                    no_port_o
);
  logic [IDX_W-1:0] cur_q, rr_q;
  logic [LEN_W-1:0] cnt_q;
  logic             np_q, fresh_q;

  logic [N_MST-1:0] cur_oh, oth_req;
  logic             all_any, oth_any;
  logic [IDX_W-1:0] all_win, oth_win, win;
  logic             cur_sel, cur_lock, cur_end;
  htrans_e          cur_tr;
  act_e             act;

  assign cur_oh  = {{(N_MST-1){1'b0}}, 1'b1} << cur_q;
  assign oth_req = sel_i & ~cur_oh;

  sm_master_pick #(.N_MST(N_MST)) u_pick_all (
    .req_i (sel_i),
    .prio_i(prio_i),
    .last_i(rr_q),
    .any_o (all_any),
    .win_o (all_win)
  );

  sm_master_pick #(.N_MST(N_MST)) u_pick_oth (
    .req_i (oth_req),
    .prio_i(prio_i),
    .last_i(rr_q),
    .any_o (oth_any),
    .win_o (oth_win)
  );

  assign cur_sel  = sel_i[cur_q];
  assign cur_lock = lock_i[cur_q];
  assign cur_tr   = htrans_e'(trans_i[cur_q*2 +: 2]);
  assign cur_end  = !cur_sel || cur_tr == TR_IDLE || (cur_tr == TR_NONSEQ && !fresh_q);

  always_comb begin
    if (np_q)              act = all_any ? ACT_PICK_ALL : ACT_RELEASE;
    else if (cur_lock)     act = ACT_KEEP;
    else if (cnt_q == '0)  act = oth_any ? ACT_PICK_OTH : (cur_sel ? ACT_KEEP : ACT_RELEASE);
    else if (cur_end)      act = all_any ? ACT_PICK_ALL : ACT_RELEASE;
    else                   act = ACT_KEEP_DEC;
  end

  assign win = (act == ACT_PICK_OTH) ? oth_win : all_win;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q   <= '0;
      rr_q    <= IDX_W'(N_MST - 1);
      cnt_q   <= '0;
      np_q    <= 1'b1;
      fresh_q <= 1'b0;
    end else if (ready_i) begin
      unique case (act)
        ACT_PICK_ALL, ACT_PICK_OTH: begin
          cur_q   <= win;
          rr_q    <= win;
          cnt_q   <= load_i[win*LEN_W +: LEN_W];
          np_q    <= 1'b0;
          fresh_q <= 1'b1;
        end
        ACT_RELEASE: np_q <= 1'b1;
        ACT_KEEP_DEC: begin
          cnt_q   <= cnt_q - LEN_W'(1);
          fresh_q <= 1'b0;
        end
        default: fresh_q <= 1'b0;
      endcase
    end
  end

  assign cur_o     = cur_q;
  assign no_port_o = np_q;
endmodule

// File: rtl/sm_port_arbiter.sv
module sm_port_arbiter
  import sm_arb_pkg::*;
#(
  parameter int N_MST = 8,
  localparam int IDX_W = $clog2(N_MST)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_MST-1:0]       sel_i,
  input  logic [N_MST*CTL_W-1:0] addr_ctl_i,
  input  logic [N_MST*2-1:0]     trans_i,
  input  logic [N_MST-1:0]       lock_i,
  input  logic                   ready_i,
  output logic [IDX_W-1:0]       grant_idx_o,
  output logic                   no_port_o,
  output logic [1:0]             trans_o
);
  logic [N_MST*PRIO_W-1:0] prio;
  logic [N_MST*LEN_W-1:0]  load;

  sm_field_extract #(.N_MST(N_MST)) u_fields (
    .addr_ctl_i(addr_ctl_i),
    .prio_o    (prio),
    .load_o    (load)
  );

  sm_arb_ctrl #(.N_MST(N_MST)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (sel_i),
    .trans_i  (trans_i),
    .lock_i   (lock_i),
    .ready_i  (ready_i),
    .prio_i   (prio),
    .load_i   (load),
    .cur_o    (grant_idx_o),
    .no_port_o(no_port_o)
  );

  always_comb begin
    if (no_port_o) trans_o = TR_IDLE;
    else           trans_o = trans_i[grant_idx_o*2 +: 2];
  end
endmodule

// File: rtl/sm_port_arbiter_chk.sv
module sm_port_arbiter_chk #(
  parameter int N_MST = 8,
  localparam int IDX_W = $clog2(N_MST)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_MST-1:0] sel_i,
  input logic [N_MST-1:0] lock_i,
  input logic             ready_i,
  input logic [IDX_W-1:0] grant_idx_o,
  input logic             no_port_o
);
  logic [N_MST-1:0] sel_d;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_d <= '0;
    else         sel_d <= sel_i;
  end

  AST_STALL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_i |=> $stable(grant_idx_o) && $stable(no_port_o)); // R10

  AST_LOCK_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i && !no_port_o && lock_i[grant_idx_o]
    |=> !no_port_o && grant_idx_o == $past(grant_idx_o)); // R6

  AST_IDLE_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i && no_port_o && sel_i == '0 |=> no_port_o); // R3

  AST_NEW_OWNER_ASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i |=> no_port_o || grant_idx_o == $past(grant_idx_o) || sel_d[grant_idx_o]); // R5

  AST_ALL_DROP_FREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i && !no_port_o && !lock_i[grant_idx_o] && sel_i == '0 |=> no_port_o); // R9
endmodule

bind sm_port_arbiter sm_port_arbiter_chk #(.N_MST(N_MST)) u_chk (.*);

// File: tb/tb_sm_port_arbiter.sv
module tb_sm_port_arbiter;
  localparam int N = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] sel_i = '0, ns_m = '0, idle_m = '0, lock_i = '0;
  logic         ready_i = 1'b0;
  logic [2:0]   prio_a [N];
  logic [3:0]   len_a  [N];
  logic [N*7-1:0] addr_ctl_i;
  logic [N*2-1:0] trans_i;
  logic [2:0]   grant_idx_o;
  logic         no_port_o;
  logic [1:0]   trans_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  always_comb begin
    for (int m = 0; m < N; m++) begin
      addr_ctl_i[m*7 +: 7] = {prio_a[m], len_a[m]};
      if (!sel_i[m] || idle_m[m]) trans_i[m*2 +: 2] = 2'd0;
      else if (ns_m[m])           trans_i[m*2 +: 2] = 2'd2;
      else                        trans_i[m*2 +: 2] = 2'd3;
    end
  end

  sm_port_arbiter dut (.*);

  typedef struct packed {
    logic [7:0] sel; logic [7:0] ns; logic rdy; logic [2:0] idx; logic np;
  } vec_t;
  localparam vec_t TBL [13] = '{
    '{8'h00, 8'h00, 1'b1, 3'd0, 1'b1},  // R3
    '{8'h05, 8'h05, 1'b1, 3'd0, 1'b0},  // R4 from reset pointer
    '{8'h05, 8'h00, 1'b1, 3'd0, 1'b0},  // R7
    '{8'h05, 8'h00, 1'b1, 3'd2, 1'b0},  // R7 switch
    '{8'h01, 8'h01, 1'b0, 3'd2, 1'b0},  // R10
    '{8'h05, 8'h01, 1'b1, 3'd2, 1'b0},
    '{8'h05, 8'h05, 1'b1, 3'd0, 1'b0},  // R9 nonseq ends, R4 wrap
    '{8'h03, 8'h02, 1'b1, 3'd0, 1'b0},
    '{8'h03, 8'h02, 1'b1, 3'd1, 1'b0},  // R7
    '{8'h02, 8'h00, 1'b1, 3'd1, 1'b0},  // R8 keep
    '{8'h00, 8'h00, 1'b1, 3'd1, 1'b1},  // R8 release
    '{8'h04, 8'h04, 1'b1, 3'd2, 1'b0},
    '{8'h00, 8'h00, 1'b1, 3'd2, 1'b1}   // R9 select drop
  };

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(logic [N-1:0] s, logic [N-1:0] ns, logic [N-1:0] lk, logic r);
    @(negedge clk_i);
    sel_i = s; ns_m = ns; lock_i = lk; ready_i = r;
    @(posedge clk_i); #1;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; sel_i = '0; ns_m = '0; idle_m = '0; lock_i = '0; ready_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int m = 0; m < N; m++) begin prio_a[m] = 3'd2; len_a[m] = 4'd4; end
    len_a[0] = 4'd2; len_a[1] = 4'd1; len_a[2] = 4'd3;
    do_reset();
    #1;
    check("R1 idx", int'(grant_idx_o), 0);
    check("R1 no_port", int'(no_port_o), 1);
    check("R1 trans", int'(trans_o), 0);

    for (int i = 0; i < 13; i++) begin
      step(TBL[i].sel, TBL[i].ns, '0, TBL[i].rdy);
      check($sformatf("R3 R4 R7 R8 R9 R10 row %0d idx", i), int'(grant_idx_o), int'(TBL[i].idx));
      check($sformatf("R3 R4 R7 R8 R9 R10 row %0d no_port", i), int'(no_port_o), int'(TBL[i].np));
    end

    // R5 / R2 priority field, R11 registered output, R9 idle end
    do_reset();
    prio_a[3] = 3'd5; prio_a[5] = 3'd1; prio_a[6] = 3'd5;
    len_a[3] = 4'd1; len_a[6] = 4'd3;
    @(negedge clk_i);
    sel_i = 8'h68; ns_m = 8'h68; ready_i = 1'b1;
    #1;
    check("R11 before edge", int'(no_port_o), 1);
    check("R12 idle without owner", int'(trans_o), 0);
    @(posedge clk_i); #1;
    check("R5 highest lowest idx", int'(grant_idx_o), 3);
    check("R12 follows owner", int'(trans_o), 2);
    step(8'h68, 8'h00, '0, 1'b1);
    check("R5 expired to m6", int'(grant_idx_o), 6);
    @(negedge clk_i);
    idle_m = 8'h40; prio_a[6] = 3'd0; sel_i = 8'h60;
    @(posedge clk_i); #1;
    check("R9 idle ends", int'(grant_idx_o), 5);
    idle_m = '0;

    // R6 lock beyond expiry
    do_reset();
    for (int m = 0; m < N; m++) begin prio_a[m] = 3'd0; len_a[m] = 4'd1; end
    step(8'h03, 8'h03, '0, 1'b1);
    check("R6 first owner", int'(grant_idx_o), 0);
    for (int k = 0; k < 3; k++) begin
      step(8'h03, 8'h00, 8'h01, 1'b1);
      check("R6 locked", int'(grant_idx_o), 0);
    end
    step(8'h03, 8'h00, '0, 1'b1);
    check("R6 unlocked switch", int'(grant_idx_o), 1);

    // R2 length code 0 = 16 beats, R7
    do_reset();
    len_a[4] = 4'd0;
    step(8'h90, 8'h90, '0, 1'b1);
    check("R2 owner m4", int'(grant_idx_o), 4);
    for (int k = 0; k < 15; k++) step(8'h90, 8'h00, '0, 1'b1);
    check("R2 held 15 edges", int'(grant_idx_o), 4);
    step(8'h90, 8'h00, '0, 1'b1);
    check("R7 16th edge switch", int'(grant_idx_o), 7);
    check("R12 seq passes", int'(trans_o), 3);

    finish_run();
  end
endmodule